// File: doc/BRIEF.md
# Serially Loaded DAC Code Latches

This block sits between a byte-oriented serial control port and three digital-to-analogue converter channels. It takes bytes that the serial shifter has already assembled and reads each frame as one command byte followed by data bytes. From these it maintains, for every channel, a latched output code, a resolution setting of 8 or 10 bits and an output-drive enable.

The resolution of a channel decides how long its load command is. An 8-bit channel takes one data byte. A 10-bit channel takes two data bytes: the first gives the top two bits and the second gives the low eight. The latched code changes only when the last data byte of a load arrives. If a transfer is cut short by the start of a new frame, it leaves the latch untouched. The resolution can be changed while the block is running, and doing so does not alter the code already held.

Top module: `dac_latch_loader`

## Requirements
- R1: After reset every channel holds code 0, is set to 8-bit resolution (`dac_res10` bit low) and is disabled (`dac_en` bit low, meaning its output is high-impedance).
- R2: A load to an 8-bit channel is command byte `0x1c`, where c is the channel number, followed by one data byte D. Starting on the clock after D, the channel's code reads `{2'b00, D}`.
- R3: A load to a 10-bit channel is command byte `0x1c` followed by bytes A and B. The code stays unchanged after A. Starting on the clock after B, the code reads `{A[1:0], B}`.
- R4: When a byte marked as frame start arrives before a load has received all of its data bytes, that load is dropped and the latch keeps its previous code. The new byte is decoded as a fresh command.
- R5: Command `0x2c` followed by data byte D sets channel c to 10-bit resolution when D[0]=1 and to 8-bit resolution when D[0]=0. The latched code is not changed.
- R6: Command `0x3c` followed by data byte D enables channel c when D[0]=1 and disables it when D[0]=0. The code and resolution are not changed.
- R7: Nothing changes for a command with an upper nibble other than 1, 2 or 3, for a command whose lower nibble is 3 or more, or for data bytes that follow a completed transfer within the same frame.
- R8: A command acts only on the channel it addresses. At most one channel's code changes on any clock.
- R9: Bytes presented while `byte_vld` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | `byte_dat` holds a received byte this cycle |
| byte_sof | input | 1 | This byte opens a frame and is a command byte |
| byte_dat | input | 8 | Received byte |
| dac_code | output | NCH*CODE_W | Latched codes, channel i at bits [i*CODE_W +: CODE_W] |
| dac_en | output | NCH | Per-channel drive enable. Low means high-impedance output |
| dac_res10 | output | NCH | Per-channel resolution. High means 10-bit |

## Verification
The bench builds the block with its default parameters: three channels and a 10-bit code. With these values, the command byte with channel field 3 is the first address that lies past the last channel, so the out-of-range case can be driven through the normal port. Each resolution can be set both ways, so one channel is moved to 10-bit and back to 8-bit while other channels hold their codes. A 10-bit load whose high bits are `2'b10` shows that the two top bits are placed in the right positions.

// File: rtl/dac_latch_loader.sv
module dac_latch_loader #(
  parameter int NCH    = 3,
  parameter int CODE_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_vld,
  input  logic                  byte_sof,
  input  logic [7:0]            byte_dat,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        dac_en,
  output logic [NCH-1:0]        dac_res10
);
  localparam int HI_W = CODE_W - 8;
  localparam logic [3:0] OP_LOAD = 4'h1;
  localparam logic [3:0] OP_RES  = 4'h2;
  localparam logic [3:0] OP_EN   = 4'h3;

  typedef enum logic [1:0] {S_SKIP, S_D1, S_D2} st_t;

  st_t             st_q;
  logic [3:0]      op_q;
  logic [NCH-1:0]  sel_q, sel_d;
  logic [HI_W-1:0] hi_q;

  always_comb
    for (int i = 0; i < NCH; i++) sel_d[i] = (byte_dat[3:0] == 4'(i));

  wire known_op = (byte_dat[7:4] == OP_LOAD) || (byte_dat[7:4] == OP_RES) ||
                  (byte_dat[7:4] == OP_EN);
  wire cmd_ok   = known_op && (|sel_d);
  wire data_ok  = byte_vld && !byte_sof;
  wire first    = data_ok && (st_q == S_D1);
  wire second   = data_ok && (st_q == S_D2);
  wire res_sel  = |(sel_q & dac_res10);
  wire wr8      = first && (op_q == OP_LOAD) && !res_sel;
  wire wr10     = second;
  wire set_res  = first && (op_q == OP_RES);
  wire set_en   = first && (op_q == OP_EN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_SKIP;
      op_q  <= '0;
      sel_q <= '0;
      hi_q  <= '0;
    end else if (byte_vld && byte_sof) begin
      st_q  <= cmd_ok ? S_D1 : S_SKIP;
      op_q  <= byte_dat[7:4];
      sel_q <= sel_d;
    end else if (first) begin
      st_q <= (op_q == OP_LOAD && res_sel) ? S_D2 : S_SKIP;
      hi_q <= byte_dat[HI_W-1:0];
    end else if (second) begin
      st_q <= S_SKIP;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q       <= '0;
        dac_en[g]    <= 1'b0;
        dac_res10[g] <= 1'b0;
      end else if (sel_q[g]) begin
        if (wr8)     code_q       <= {{HI_W{1'b0}}, byte_dat};
        if (wr10)    code_q       <= {hi_q, byte_dat};
        if (set_res) dac_res10[g] <= byte_dat[0];
        if (set_en)  dac_en[g]    <= byte_dat[0];
      end
    end
    assign dac_code[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

module dac_latch_loader_chk #(
  parameter int NCH    = 3,
  parameter int CODE_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  byte_vld,
  input logic                  byte_sof,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        dac_en,
  input logic [NCH-1:0]        dac_res10
);
  logic [NCH*CODE_W-1:0] prev_q;
  logic [NCH-1:0]        chg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= dac_code;

  always_comb
    for (int i = 0; i < NCH; i++)
      chg[i] = dac_code[i*CODE_W +: CODE_W] != prev_q[i*CODE_W +: CODE_W];

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> ($stable(dac_code) && $stable(dac_en) && $stable(dac_res10)));

  assert_cmd_byte_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && byte_sof) |=> ($stable(dac_code) && $stable(dac_en) && $stable(dac_res10)));

  assert_res_keeps_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_res10) |-> ($stable(dac_code) && $stable(dac_en)));

  assert_en_keeps_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_en) |-> ($stable(dac_code) && $stable(dac_res10)));

  assert_one_channel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));
endmodule

bind dac_latch_loader dac_latch_loader_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
  .dac_code(dac_code), .dac_en(dac_en), .dac_res10(dac_res10));

// File: tb/sim_dac_latch_loader.sv
module sim_dac_latch_loader;
  localparam int NCH = 3;
  localparam int CW  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0, byte_sof = 1'b0;
  logic [7:0] byte_dat = '0;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0] dac_en, dac_res10;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dac_latch_loader #(.NCH(NCH), .CODE_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_sof(byte_sof),
    .byte_dat(byte_dat), .dac_code(dac_code), .dac_en(dac_en), .dac_res10(dac_res10));

  // {sof, byte, check, chan, code, en, res10, req}
  localparam int NV = 29;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 8'h10, 1'b0, 2'd0, 10'h000, 1'b0, 1'b0, 4'd2},
    {1'b0, 8'hA5, 1'b1, 2'd0, 10'h0A5, 1'b0, 1'b0, 4'd2},  // R2
    {1'b1, 8'h21, 1'b0, 2'd1, 10'h000, 1'b0, 1'b0, 4'd5},
    {1'b0, 8'h01, 1'b1, 2'd1, 10'h000, 1'b0, 1'b1, 4'd5},  // R5
    {1'b1, 8'h11, 1'b0, 2'd1, 10'h000, 1'b0, 1'b1, 4'd3},
    {1'b0, 8'h03, 1'b1, 2'd1, 10'h000, 1'b0, 1'b1, 4'd3},  // R3 hold after first byte
    {1'b0, 8'h5C, 1'b1, 2'd1, 10'h35C, 1'b0, 1'b1, 4'd3},  // R3
    {1'b1, 8'h32, 1'b0, 2'd2, 10'h000, 1'b0, 1'b0, 4'd6},
    {1'b0, 8'h01, 1'b1, 2'd2, 10'h000, 1'b1, 1'b0, 4'd6},  // R6
    {1'b1, 8'h11, 1'b0, 2'd1, 10'h35C, 1'b0, 1'b1, 4'd4},
    {1'b0, 8'h02, 1'b1, 2'd1, 10'h35C, 1'b0, 1'b1, 4'd4},  // R4
    {1'b1, 8'h12, 1'b1, 2'd1, 10'h35C, 1'b0, 1'b1, 4'd4},  // R4 truncated
    {1'b0, 8'h77, 1'b1, 2'd2, 10'h077, 1'b1, 1'b0, 4'd2},  // R2 after truncation
    {1'b0, 8'h55, 1'b1, 2'd2, 10'h077, 1'b1, 1'b0, 4'd7},  // R7 extra byte
    {1'b1, 8'h40, 1'b0, 2'd0, 10'h0A5, 1'b0, 1'b0, 4'd7},
    {1'b0, 8'h99, 1'b1, 2'd0, 10'h0A5, 1'b0, 1'b0, 4'd7},  // R7 unknown op
    {1'b1, 8'h13, 1'b0, 2'd2, 10'h077, 1'b1, 1'b0, 4'd7},
    {1'b0, 8'h44, 1'b1, 2'd2, 10'h077, 1'b1, 1'b0, 4'd7},  // R7 bad channel
    {1'b1, 8'h21, 1'b0, 2'd1, 10'h35C, 1'b0, 1'b1, 4'd5},
    {1'b0, 8'h00, 1'b1, 2'd1, 10'h35C, 1'b0, 1'b0, 4'd5},  // R5 back to 8-bit
    {1'b1, 8'h11, 1'b0, 2'd1, 10'h35C, 1'b0, 1'b0, 4'd2},
    {1'b0, 8'hE4, 1'b1, 2'd1, 10'h0E4, 1'b0, 1'b0, 4'd2},  // R2
    {1'b1, 8'h30, 1'b0, 2'd0, 10'h0A5, 1'b0, 1'b0, 4'd6},
    {1'b0, 8'hFF, 1'b1, 2'd0, 10'h0A5, 1'b1, 1'b0, 4'd6},  // R6
    {1'b1, 8'h20, 1'b0, 2'd0, 10'h0A5, 1'b1, 1'b0, 4'd5},
    {1'b0, 8'h01, 1'b1, 2'd0, 10'h0A5, 1'b1, 1'b1, 4'd5},  // R5
    {1'b1, 8'h10, 1'b0, 2'd0, 10'h0A5, 1'b1, 1'b1, 4'd3},
    {1'b0, 8'hFE, 1'b1, 2'd0, 10'h0A5, 1'b1, 1'b1, 4'd3},  // R3
    {1'b0, 8'h01, 1'b1, 2'd0, 10'h201, 1'b1, 1'b1, 4'd3}   // R3
  };

  task automatic check(input int ch, input logic [CW-1:0] code, input logic en,
                       input logic res, input int req);
    logic [CW-1:0] a_code;
    a_code = dac_code[ch*CW +: CW];
    n_chk++;
    if (a_code !== code || dac_en[ch] !== en || dac_res10[ch] !== res) begin
      n_fail++;
      $display("FAIL R%0d ch%0d: code=%h en=%b res=%b expected code=%h en=%b res=%b",
               req, ch, a_code, dac_en[ch], dac_res10[ch], code, en, res);
    end
  endtask

  task automatic send(input logic sof, input logic [7:0] d, input logic vld);
    @(negedge clk);
    byte_vld = vld; byte_sof = sof; byte_dat = d;
    @(negedge clk);
    byte_vld = 1'b0; byte_sof = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) check(c, '0, 1'b0, 1'b0, 1);  // R1
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][27], VEC[i][26:19], 1'b1);
      if (VEC[i][18]) check(int'(VEC[i][17:16]), VEC[i][15:6], VEC[i][5], VEC[i][4],
                            int'(VEC[i][3:0]));
    end
    // R8: every channel kept its own state
    check(0, 10'h201, 1'b1, 1'b1, 8);
    check(1, 10'h0E4, 1'b0, 1'b0, 8);
    check(2, 10'h077, 1'b1, 1'b0, 8);
    // R9: bytes without valid are ignored
    send(1'b1, 8'h12, 1'b0);
    send(1'b0, 8'h3C, 1'b0);
    check(2, 10'h077, 1'b1, 1'b0, 9);
    send(1'b0, 8'h3C, 1'b1);  // stray data byte, stream is idle
    check(2, 10'h077, 1'b1, 1'b0, 9);
    // R1: reset during activity
    send(1'b1, 8'h10, 1'b1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) check(c, '0, 1'b0, 1'b0, 1);
    rst_n = 1'b1;
    send(1'b0, 8'h66, 1'b1);
    check(0, '0, 1'b0, 1'b0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule